// File: doc/BRIEF.md
# Per-Chip-Select SPI Transaction Engine

This block is the serial core of an SPI master. A single command word names one of four chip selects and a frame length in bytes. When the command is taken, the engine latches that chip select's mode word. The mode word fixes the clock polarity and phase, bit order, character length, clock rate, chip-select polarity, setup and hold delays and the gap between characters. The engine then runs the whole frame without further intervention.

During the frame the engine holds the chip select active. It pulls characters of 4 to 16 bits from a transmit FIFO and shifts them out on the data output. It assembles the received bits into characters and pushes them to a receive FIFO. A loopback control routes the serial output back to the serial input inside the block. Register decoding sits outside: the command, the four mode words and both FIFO sides arrive as ports.

Top module: `spi_xact_engine`

## Requirements
- R1: A command is taken only when `cmd_valid` is high, `glb_en` is high and no frame is running. Bits 31:30 of `cmd_word` pick the chip select and bits 15:0 hold the byte count minus one. The mode word of that chip select is latched when the command is taken. A command offered while disabled or busy has no effect.
- R2: Mode word bit 20 sets the chip-select polarity: 1 means active low, 0 means active high. Only the addressed chip select leaves its idle level, and it stays active from the accepted command until release. All others hold their idle level.
- R3: Serial clock period = 4 × (P + 1) input clocks, where P is the mode field in bits 27:24. Bit 28 multiplies the period by 16. A P below 2 gives the same period as P = 2.
- R4: Mode bit 31 = 1 makes the clock idle high, and 0 makes it idle low. The clock rests at this level outside the shifting phase of a frame.
- R5: Mode bit 30 = 0: data is sampled on the leading clock edge and changes on the trailing edge. Mode bit 30 = 1: data changes on the leading edge and is sampled on the trailing edge.
- R6: Bits 19:16 hold the character length minus one. Characters are right-justified in `tx_data` and `rx_data`. Mode bit 29 = 1 sends the most significant bit first, and 0 sends the least significant bit first.
- R7: A frame shifts exactly 8 × (byte count) bits. The final character is cut short to the remaining bits, taken in transmit order. Its unsent positions read as zero in `rx_data`.
- R8: Bits 15:12 (B) set the setup delay. The first clock edge follows chip-select assertion by 2·B·H + H + 1 input clocks, where H is half the clock period.
- R9: Bits 11:8 (A) set the hold delay. The chip select is released 2·A·H input clocks after the last clock edge. `done` pulses for exactly one cycle, in the same cycle as the release.
- R10: Bits 7:3 (G) set the gap. Between characters of one frame, the clock rests for 2·G·H + H + 1 input clocks from the last edge of one character to the first edge of the next.
- R11: With `loopback` high, the received bits are the transmitted bits, and the `miso` pin is ignored.
- R12: When a character is due and the transmit FIFO is empty, the clock stalls with the chip select still active. Shifting resumes when data arrives. `tx_pop` is never raised on an empty FIFO.
- R13: `rx_push` pulses once per character, after that character's last clock edge, with the received character on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable; commands are ignored while low |
| loopback | input | 1 | Route serial output to serial input |
| cmd_valid | input | 1 | Command offered |
| cmd_word | input | 32 | Chip select in 31:30, byte count minus one in 15:0 |
| cs_cfg | input | 128 | Four 32-bit mode words, chip select 0 in the low word |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 16 | Head of the transmit FIFO |
| tx_pop | output | 1 | Takes the transmit FIFO head this cycle |
| rx_push | output | 1 | Received character valid |
| rx_data | output | 16 | Received character |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at chip-select release |

## Verification
The case hardest to reach from the ports is a frame that stalls mid-way on an empty transmit FIFO, with the chip select still held. A second command arrives during that stall and must be ignored. The bench queues a single character for a two-byte frame and waits well beyond one character time. It then checks that the clock edge count is frozen at one character and that the chip select is still active. It offers a competing command to another chip select before supplying the second word. The delay arithmetic is checked by timing the edges in input-clock cycles: first clock edge, gap between characters and release. The expected cycle counts are derived from the requirement formulas.

// File: rtl/spi_xe_pkg.sv
package spi_xe_pkg;
  localparam int CHAR_W = 16;
  localparam int HL_W   = 10;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic       msb;
    logic       div16;
    logic [3:0] pm;
    logic [2:0] rsv_hi;
    logic       cs_pol;
    logic [3:0] clen;
    logic [3:0] bef;
    logic [3:0] aft;
    logic [4:0] gap;
    logic [2:0] rsv_lo;
  } cs_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOAD, ST_SHIFT, ST_GAP, ST_HOLD
  } st_t;

  // Input clocks per half serial-clock period, minus one.
  function automatic logic [HL_W-1:0] half_limit(input logic [3:0] pm, input logic d16);
    logic [HL_W-1:0] p, base;
    p    = (pm < 4'd2) ? HL_W'(2) : HL_W'(pm);
    base = (p + HL_W'(1)) << 1;
    return d16 ? ((base << 4) - HL_W'(1)) : (base - HL_W'(1));
  endfunction

  // Position inside a right-justified character of the b-th bit on the wire.
  function automatic logic [3:0] bit_pos(input logic msb, input logic [3:0] clen,
                                         input logic [3:0] b);
    return msb ? (clen - b) : b;
  endfunction
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] hlim,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == hlim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr || !run || tick) cnt <= '0;
    else                         cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_char_shift.sv
module spi_char_shift
  import spi_xe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] tx_word,
  input  logic              msb,
  input  logic [3:0]        clen,
  input  logic [4:0]        nbits,
  input  logic              cpha,
  input  logic              lead_tick,
  input  logic              trail_tick,
  input  logic              sin,
  output logic              sout,
  output logic              char_end,
  output logic [CHAR_W-1:0] rx_word
);
  logic [3:0]        b;
  logic [CHAR_W-1:0] txw, rxw, rx_nxt;
  logic [3:0]        pos_b, pos_n;
  logic              last_bit, sample_now;

  assign pos_b      = bit_pos(msb, clen, b);
  assign pos_n      = bit_pos(msb, clen, b + 4'd1);
  assign last_bit   = ({1'b0, b} == (nbits - 5'd1));
  assign char_end   = trail_tick && last_bit;
  assign sample_now = cpha ? trail_tick : lead_tick;

  always_comb begin
    rx_nxt = rxw;
    if (sample_now) rx_nxt[pos_b] = sin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b <= '0; txw <= '0; rxw <= '0; sout <= 1'b0; rx_word <= '0;
    end else if (load) begin
      txw <= tx_word;
      b   <= '0;
      rxw <= '0;
      if (!cpha) sout <= tx_word[bit_pos(msb, clen, 4'd0)];
    end else begin
      rxw <= rx_nxt;
      if (lead_tick && cpha) sout <= txw[pos_b];
      if (trail_tick && !last_bit) begin
        b <= b + 4'd1;
        if (!cpha) sout <= txw[pos_n];
      end
      if (char_end) rx_word <= rx_nxt;
    end
  end
endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine
  import spi_xe_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int LEN_W  = 16,
  parameter int CMD_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 glb_en,
  input  logic                 loopback,
  input  logic                 cmd_valid,
  input  logic [CMD_W-1:0]     cmd_word,
  input  logic [NUM_CS*32-1:0] cs_cfg,
  input  logic                 tx_empty,
  input  logic [CHAR_W-1:0]    tx_data,
  output logic                 tx_pop,
  output logic                 rx_push,
  output logic [CHAR_W-1:0]    rx_data,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic [NUM_CS-1:0]    cs_o,
  output logic                 busy,
  output logic                 done
);
  localparam int CS_W   = $clog2(NUM_CS);
  localparam int BITS_W = LEN_W + 4;

  st_t              st, st_n;
  cs_cfg_t          cfg, new_cfg;
  logic [CS_W-1:0]  sel, cmd_cs;
  logic [LEN_W-1:0] cmd_len;
  logic [BITS_W-1:0] bits_left;
  logic [6:0]       hcnt;
  logic             sclk_q, done_q, rx_push_q;

  // Named internal events
  logic             accept, tick, lead_tick, trail_tick, char_end, last_char;
  logic             hc_done, release_ev, sin;
  logic [4:0]       clen5, nbits;
  logic [HL_W-1:0]  hlim;

  assign cmd_cs  = cmd_word[CMD_W-1 -: CS_W];
  assign cmd_len = cmd_word[LEN_W-1:0];
  assign new_cfg = cs_cfg_t'(cs_cfg[cmd_cs*32 +: 32]);
  assign accept  = (st == ST_IDLE) && cmd_valid && glb_en;

  assign hlim       = half_limit(cfg.pm, cfg.div16);
  assign clen5      = {1'b0, cfg.clen} + 5'd1;
  assign nbits      = (bits_left >= BITS_W'(clen5)) ? clen5 : bits_left[4:0];
  assign last_char  = (bits_left == BITS_W'(nbits));
  assign lead_tick  = tick && (st == ST_SHIFT) && !sclk_q;
  assign trail_tick = tick && (st == ST_SHIFT) && sclk_q;
  assign hc_done    = tick && (hcnt == 7'd0);
  assign tx_pop     = (st == ST_LOAD) && !tx_empty;
  assign release_ev = (st != ST_IDLE) && (st_n == ST_IDLE);
  assign sin        = loopback ? mosi : miso;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:  if (accept) st_n = (new_cfg.bef != 4'd0) ? ST_SETUP : ST_LOAD;
      ST_SETUP: if (hc_done) st_n = ST_LOAD;
      ST_LOAD:  if (!tx_empty) st_n = ST_SHIFT;
      ST_SHIFT: if (char_end) begin
                  if (last_char) st_n = (cfg.aft != 4'd0) ? ST_HOLD : ST_IDLE;
                  else           st_n = (cfg.gap != 5'd0) ? ST_GAP  : ST_LOAD;
                end
      ST_GAP:   if (hc_done) st_n = ST_LOAD;
      ST_HOLD:  if (hc_done) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  spi_half_tick #(.CNT_W(HL_W)) i_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (st_n != st),
    .run  ((st != ST_IDLE) && (st != ST_LOAD)),
    .hlim (hlim),
    .tick (tick)
  );

  spi_char_shift i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_pop),
    .tx_word   (tx_data),
    .msb       (cfg.msb),
    .clen      (cfg.clen),
    .nbits     (nbits),
    .cpha      (cfg.cpha),
    .lead_tick (lead_tick),
    .trail_tick(trail_tick),
    .sin       (sin),
    .sout      (mosi),
    .char_end  (char_end),
    .rx_word   (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cfg <= '0; sel <= '0; bits_left <= '0; hcnt <= '0;
      sclk_q <= 1'b0; done_q <= 1'b0; rx_push_q <= 1'b0;
    end else begin
      st        <= st_n;
      done_q    <= release_ev;
      rx_push_q <= char_end;
      if (accept) begin
        cfg       <= new_cfg;
        sel       <= cmd_cs;
        bits_left <= (BITS_W'(cmd_len) + BITS_W'(1)) << 3;
        hcnt      <= {2'b0, new_cfg.bef, 1'b0} - 7'd1;
      end
      if (tick && (st inside {ST_SETUP, ST_GAP, ST_HOLD}) && (hcnt != 7'd0))
        hcnt <= hcnt - 7'd1;
      if (lead_tick)  sclk_q <= 1'b1;
      if (trail_tick) sclk_q <= 1'b0;
      if (char_end) begin
        bits_left <= bits_left - BITS_W'(nbits);
        if (last_char) hcnt <= {2'b0, cfg.aft, 1'b0} - 7'd1;
        else           hcnt <= {1'b0, cfg.gap, 1'b0} - 7'd1;
      end
    end
  end

  assign busy    = (st != ST_IDLE);
  assign done    = done_q;
  assign rx_push = rx_push_q;
  assign sclk    = cfg.cpol ^ sclk_q;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_o[i] = cs_cfg[i*32 + 20] ^ (busy && (sel == CS_W'(i)));
  end
endmodule

// File: rtl/spi_xact_engine_chk.sv
module spi_xact_engine_chk
  import spi_xe_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 glb_en,
  input logic [NUM_CS*32-1:0] cs_cfg,
  input logic [NUM_CS-1:0]    cs_o,
  input logic                 tx_pop,
  input logic                 tx_empty,
  input logic                 rx_push,
  input logic                 done,
  input logic                 busy,
  input logic                 sclk,
  input st_t                  st
);
  logic [NUM_CS-1:0] idle_lvl;
  always_comb
    for (int i = 0; i < NUM_CS; i++) idle_lvl[i] = cs_cfg[i*32 + 20];

  assert_one_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o ^ idle_lvl));

  assert_pop_nonempty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_sclk_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> ($past(st) == ST_SHIFT || $past(st) == ST_IDLE));

  assert_disabled_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !glb_en) |=> (st == ST_IDLE));

  assert_push_from_shift_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $past(st == ST_SHIFT));
endmodule

bind spi_xact_engine spi_xact_engine_chk #(.NUM_CS(NUM_CS)) i_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cs_cfg(cs_cfg), .cs_o(cs_o),
  .tx_pop(tx_pop), .tx_empty(tx_empty), .rx_push(rx_push), .done(done),
  .busy(busy), .sclk(sclk), .st(st)
);

// File: tb/test_spi_xact_engine.sv
module test_spi_xact_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, glb_en, loopback, cmd_valid, miso;
  logic [31:0] cmd_word;
  logic [31:0] cfg_w [4];
  logic [127:0] cs_cfg;
  logic        tx_empty, tx_pop, rx_push, sclk, mosi, busy, done;
  logic [15:0] tx_data, rx_data;
  logic [3:0]  cs_o;

  assign cs_cfg = {cfg_w[3], cfg_w[2], cfg_w[1], cfg_w[0]};

  spi_xact_engine i_spi_xact_engine (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .loopback(loopback),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cs_cfg(cs_cfg),
    .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_o(cs_o), .busy(busy), .done(done)
  );

  // Transmit FIFO model
  logic [15:0] txq [64];
  int tx_cnt = 0, tx_ptr = 0;
  always @(posedge clk) if (tx_pop) tx_ptr <= tx_ptr + 1;
  assign tx_empty = (tx_ptr >= tx_cnt);
  assign tx_data  = txq[tx_ptr[5:0]];

  int checks = 0, errors = 0;
  int cyc = 0, n_edge = 0, n_cap = 0, n_rx = 0, n_done = 0;
  int edge_t [256];
  logic cap [256];
  logic [15:0] rx_got [16];
  logic [15:0] wq [8];
  int cs_on_t = 0, cs_off_t = 0, done_t = 0, s_idx = 0;
  int mon_cs = 0;
  logic mon_cpol = 0, mon_cpha = 0, prev_sclk = 0, prev_act = 0, slave_en = 0, other_act = 0;
  logic [15:0] slave_pat = 16'h0;

  function automatic logic [3:0] idle_vec();
    return {cfg_w[3][20], cfg_w[2][20], cfg_w[1][20], cfg_w[0][20]};
  endfunction

  // Port monitor and slave model, sampling between clock edges
  always @(negedge clk) begin
    logic act, lead;
    logic [3:0] actv;
    cyc++;
    actv = cs_o ^ idle_vec();
    act  = actv[mon_cs];
    if ((actv & ~(4'b1 << mon_cs)) != 4'b0) other_act = 1;
    if (act && !prev_act) begin
      cs_on_t = cyc;
      if (slave_en) begin s_idx = 0; miso = slave_pat[15]; end
    end
    if (!act && prev_act) cs_off_t = cyc;
    prev_act = act;
    if (sclk !== prev_sclk) begin
      lead = (sclk != mon_cpol);
      if (n_edge < 256) edge_t[n_edge] = cyc;
      n_edge++;
      if (lead ^ mon_cpha) begin if (n_cap < 256) cap[n_cap] = mosi; n_cap++; end
      if (!lead && slave_en && s_idx < 15) begin s_idx++; miso = slave_pat[15 - s_idx]; end
    end
    prev_sclk = sclk;
    if (rx_push) begin if (n_rx < 16) rx_got[n_rx] = rx_data; n_rx++; end
    if (done) begin n_done++; done_t = cyc; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input logic cpol, input logic cpha, input logic msb,
      input logic d16, input logic [3:0] pm, input logic pol, input logic [3:0] clen,
      input logic [3:0] bef, input logic [3:0] aft, input logic [4:0] gap);
    return {cpol, cpha, msb, d16, pm, 3'b0, pol, clen, bef, aft, gap, 3'b0};
  endfunction

  task automatic set_cfg(input int cs, input logic [31:0] w);
    @(negedge clk); glb_en = 0;
    cfg_w[cs] = w;
    @(negedge clk); glb_en = 1;
  endtask

  task automatic push_tx(input logic [15:0] w);
    txq[tx_cnt[5:0]] = w; tx_cnt++;
  endtask

  task automatic start(input logic [1:0] cs, input logic [15:0] len);
    n_edge = 0; n_cap = 0; n_rx = 0; n_done = 0; other_act = 0;
    mon_cs = int'(cs); mon_cpol = cfg_w[cs][31]; mon_cpha = cfg_w[cs][30];
    @(negedge clk); cmd_valid = 1; cmd_word = {cs, 14'b0, len};
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (n_done == 0 && t < 30000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_stream(input string tag, input int L, input bit msb,
                              input int total, input bit loop);
    int k = 0, bad = 0;
    for (int c = 0; k < total; c++) begin
      int nb = (total - k < L) ? total - k : L;
      logic [15:0] m = 16'h0;
      for (int b = 0; b < nb; b++) begin
        int p = msb ? L - 1 - b : b;
        m[p] = 1'b1;
        if (cap[k] !== wq[c][p]) bad++;
        k++;
      end
      if (loop) chk(rx_got[c] == (wq[c] & m), tag, rx_got[c], wq[c] & m);
    end
    chk(bad == 0, tag, bad, 0);
    chk(n_cap == total, tag, n_cap, total);
  endtask

  task automatic t_reset();
    chk(cs_o == idle_vec(), "R2 reset cs idle", cs_o, idle_vec());
    chk(!busy && !done && !tx_pop && !rx_push, "R1 reset quiet", {busy, done, tx_pop, rx_push}, 0);
    chk(sclk == 1'b0, "R4 reset sclk", sclk, 0);
  endtask

  task automatic t_basic_slave();
    set_cfg(1, mk_cfg(0, 0, 1, 0, 2, 1, 7, 0, 0, 0));
    loopback = 0; slave_en = 1; slave_pat = 16'h5AC3;
    wq[0] = 16'hA5; wq[1] = 16'h3C; push_tx(wq[0]); push_tx(wq[1]);
    start(2'd1, 16'd1);
    repeat (5) @(negedge clk);
    chk(cs_o == 4'b1001, "R2 cs1 active low", cs_o, 4'b1001);
    wait_done();
    check_stream("R6 mode0 msb-first wire", 8, 1, 16, 0);
    chk(n_rx == 2, "R13 push count", n_rx, 2);
    chk(rx_got[0] == 16'h5A, "R5 rx char0", rx_got[0], 16'h5A);
    chk(rx_got[1] == 16'hC3, "R5 rx char1", rx_got[1], 16'hC3);
    chk(n_done == 1 && cs_o == idle_vec(), "R9 released", cs_o, idle_vec());
    chk(tx_ptr == tx_cnt, "R7 pops", tx_ptr, tx_cnt);
    chk(other_act == 0, "R2 others idle", other_act, 0);
    slave_en = 0;
  endtask

  task automatic t_cs_high();
    set_cfg(2, mk_cfg(0, 0, 1, 0, 2, 0, 7, 0, 0, 0));
    loopback = 1; wq[0] = 16'h81; push_tx(wq[0]);
    start(2'd2, 16'd0);
    repeat (5) @(negedge clk);
    chk(cs_o == 4'b1111, "R2 cs2 active high", cs_o, 4'b1111);
    wait_done();
    chk(cs_o == 4'b1011, "R2 cs2 idle low", cs_o, 4'b1011);
    check_stream("R11 loop cs2", 8, 1, 8, 1);
  endtask

  task automatic t_rate();
    logic [3:0] pms [4] = '{4'd2, 4'd0, 4'd5, 4'd2};
    int exp_p [4] = '{12, 12, 24, 192};
    loopback = 1;
    for (int i = 0; i < 4; i++) begin
      set_cfg(0, mk_cfg(0, 0, 1, (i == 3), pms[i], 1, 7, 0, 0, 0));
      push_tx(16'h55);
      start(2'd0, 16'd0);
      wait_done();
      chk(edge_t[2] - edge_t[0] == exp_p[i], "R3 sclk period", edge_t[2] - edge_t[0], exp_p[i]);
    end
  endtask

  task automatic t_modes();
    loopback = 1;
    for (int m = 0; m < 4; m++) begin
      logic pol = m[1], ph = m[0], msb = (m != 1);
      set_cfg(3, mk_cfg(pol, ph, msb, 0, 3, 1, 11, 0, 0, 0));
      wq[0] = 16'h0ABC ^ 16'(m); wq[1] = 16'h0123 + 16'(m);
      push_tx(wq[0]); push_tx(wq[1]);
      start(2'd3, 16'd2);
      repeat (3) @(negedge clk);
      chk(sclk == pol, "R4 idle level in setup", sclk, pol);
      wait_done();
      check_stream("R5 R6 R11 mode loop", 12, msb, 24, 1);
      chk(sclk == pol, "R4 idle level after", sclk, pol);
    end
  endtask

  task automatic t_trunc();
    loopback = 1;
    set_cfg(0, mk_cfg(0, 0, 1, 0, 2, 1, 15, 0, 0, 0));
    wq[0] = 16'hBEEF; wq[1] = 16'h1234; push_tx(wq[0]); push_tx(wq[1]);
    start(2'd0, 16'd2);
    wait_done();
    check_stream("R7 truncated tail", 16, 1, 24, 1);
    chk(rx_got[1] == 16'h1200, "R7 tail zeros", rx_got[1], 16'h1200);
    chk(n_rx == 2, "R13 push count trunc", n_rx, 2);
  endtask

  task automatic t_short();
    loopback = 1;
    set_cfg(0, mk_cfg(0, 0, 1, 0, 2, 1, 3, 0, 0, 0));
    wq[0] = 16'hF9; wq[1] = 16'h56; push_tx(wq[0]); push_tx(wq[1]);
    start(2'd0, 16'd0);
    wait_done();
    check_stream("R6 4-bit chars", 4, 1, 8, 1);
    chk(rx_got[0] == 16'h9, "R6 right-justified", rx_got[0], 16'h9);
  endtask

  task automatic t_delays();
    loopback = 1;
    set_cfg(0, mk_cfg(0, 0, 1, 0, 2, 1, 7, 2, 1, 1));
    wq[0] = 16'hC4; wq[1] = 16'h2B; push_tx(wq[0]); push_tx(wq[1]);
    start(2'd0, 16'd1);
    wait_done();
    chk(edge_t[0] - cs_on_t == 31, "R8 setup delay", edge_t[0] - cs_on_t, 31);
    chk(edge_t[16] - edge_t[15] == 19, "R10 char gap", edge_t[16] - edge_t[15], 19);
    chk(cs_off_t - edge_t[31] == 12, "R9 hold delay", cs_off_t - edge_t[31], 12);
    chk(done_t == cs_off_t && n_done == 1, "R9 done at release", done_t, cs_off_t);
    check_stream("R10 data with delays", 8, 1, 16, 1);
  endtask

  task automatic t_stall();
    loopback = 1;
    set_cfg(0, mk_cfg(0, 0, 1, 0, 2, 1, 7, 0, 0, 0));
    wq[0] = 16'h6E; wq[1] = 16'hD1; push_tx(wq[0]);
    start(2'd0, 16'd1);
    repeat (400) @(negedge clk);
    chk(n_edge == 16, "R12 clock stalled", n_edge, 16);
    chk(busy && cs_o[0] == 1'b0, "R12 cs held in stall", cs_o, 4'b1010);
    @(negedge clk); cmd_valid = 1; cmd_word = {2'd3, 14'b0, 16'd0};
    @(negedge clk); cmd_valid = 0;
    push_tx(wq[1]);
    wait_done();
    chk(n_edge == 32, "R12 resumed", n_edge, 32);
    check_stream("R12 data after stall", 8, 1, 16, 1);
    chk(other_act == 0 && n_done == 1, "R1 busy cmd ignored", other_act, 0);
  endtask

  task automatic t_disabled();
    loopback = 1;
    @(negedge clk); glb_en = 0;
    push_tx(16'h77);
    start(2'd0, 16'd0);
    repeat (100) @(negedge clk);
    chk(n_edge == 0 && !busy, "R1 disabled no frame", n_edge, 0);
    chk(cs_o == idle_vec(), "R1 disabled cs idle", cs_o, idle_vec());
    chk(tx_ptr == tx_cnt - 1, "R1 disabled no pop", tx_ptr, tx_cnt - 1);
  endtask

  initial begin
    rst_n = 0; glb_en = 0; loopback = 0; cmd_valid = 0; cmd_word = 0; miso = 0;
    cfg_w[0] = mk_cfg(0, 0, 1, 0, 2, 1, 7, 0, 0, 1);
    cfg_w[1] = mk_cfg(0, 0, 1, 0, 2, 1, 7, 0, 0, 1);
    cfg_w[2] = mk_cfg(0, 0, 1, 0, 2, 0, 7, 0, 0, 1);
    cfg_w[3] = mk_cfg(0, 0, 1, 0, 2, 1, 7, 0, 0, 1);
    repeat (5) @(negedge clk);
    rst_n = 1; glb_en = 1;
    @(negedge clk);
    t_reset();
    t_basic_slave();
    t_cs_high();
    t_rate();
    t_modes();
    t_trunc();
    t_short();
    t_delays();
    t_stall();
    t_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule